// File: doc/BRIEF.md
# Programmable Supervisor Reset Timer

This block drives the board-level reset of a processor from two sources. The first is a digital supply-good indication from an analog comparator that sits outside the block. The second is a self-clearing software reset bit that a register interface writes. Whenever the supply is below its trip threshold, the block pulls the reset line low at once. After the supply recovers, it keeps the line low for a selectable hold time. A software request pulls the line low for the same selectable time.

The hold time is chosen by a 2-bit code from an external register: 125, 250, 500 or 1000 milliseconds. A millisecond timebase is derived from the system clock through the `CYC_PER_MS` parameter, so a simulation can shrink a millisecond to a handful of cycles. The register interface reads back three things: a trip flag, a reset-status flag and the current value of the software reset bit. The reset output is a pull-down enable for an open-drain line; the high level comes from an external pull-up.

Top module: `sup_rst_timer`

## Requirements
- R1: The hold length in clock cycles is `(125 << code) * CYC_PER_MS`, where `code` is the 2-bit delay code. Code 0 gives 125 ms, 1 gives 250 ms, 2 gives 500 ms and 3 gives 1000 ms.
- R2: When `supply_ok_i` falls, `rst_pull_o` and `trip_o` are both 1 by the third rising clock edge after the change. While `trip_o` is 1, `rst_pull_o` is 1.
- R3: After `supply_ok_i` rises, `rst_pull_o` stays 1 and returns to 0 at rising edge N+2 after the change, where N is the R1 hold length. The 2 extra edges are the input synchronizer.
- R4: If the supply drops again during a hold, the hold restarts. Release then comes N+2 edges after the last rise of `supply_ok_i`.
- R5: An edge that samples `swrst_wr_i`=1 with `swrst_data_i`=1 makes `rst_pull_o` 1 after that edge. The line is released exactly N edges after that write edge.
- R6: `swrst_bit_o` reads 1 after a software reset write. It returns to 0 on the first millisecond boundary of the hold, `CYC_PER_MS` edges after the write, while `rst_pull_o` is still 1.
- R7: A write with `swrst_data_i`=0 has no effect: `rst_pull_o` and `swrst_bit_o` stay 0.
- R8: A software reset write made while a hold is running restarts the hold for a full period counted from that write.
- R9: `rst_status_o` equals `rst_pull_o`. `trip_o` is 1 exactly while the synchronized supply indication is low.
- R10: While `rst` is high, the outputs are: `rst_pull_o`=1, `trip_o`=1, `rst_status_o`=1 and `swrst_bit_o`=0. The first hold after `rst` is released always uses code 3 (1000 ms), whatever `delay_code_i` is.
- R11: The delay code is captured when a hold starts. Changing `delay_code_i` during a hold does not change that hold's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok_i | input | 1 | Comparator output, 1 = supply above trip point (asynchronous) |
| delay_code_i | input | 2 | Hold-time code from the external delay register |
| swrst_wr_i | input | 1 | Write strobe for the software reset bit |
| swrst_data_i | input | 1 | Value written to the software reset bit |
| rst_pull_o | output | 1 | 1 = pull the open-drain reset line low |
| rst_status_o | output | 1 | Reset-status flag, 1 while reset is active |
| trip_o | output | 1 | Trip flag, 1 while the supply is below the trip point |
| swrst_bit_o | output | 1 | Read-back of the self-clearing software reset bit |

## Verification
Supply results go through a two-stage synchronizer. A supply failure is therefore due at the third edge after the input changes, and a supply recovery releases the line at edge N+2. Software results are due one edge after the write for assertion, `CYC_PER_MS` edges after it for the bit clear, and N edges after it for release. The bench drives inputs on falling edges and counts falling edges from the stimulus until the output changes. It compares that count with the exact figure worked out from these latencies, so an early or late release shows up as a wrong count.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int CODE_W = 2;
  localparam int MS_W   = 10;
  localparam logic [CODE_W-1:0] POR_CODE = 2'b11;

  function automatic logic [MS_W-1:0] hold_ms(input logic [CODE_W-1:0] code);
    return MS_W'(125) << code;
  endfunction
endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srt_ms_tick.sv
module srt_ms_tick #(
  parameter int CYC_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

  logic [PW-1:0] pre;

  assign tick = en && !clr && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre <= '0;
    else if (en) begin
      if (pre == LAST) pre <= '0;
      else             pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/srt_hold_ctrl.sv
module srt_hold_ctrl
  import srt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_i,
  output logic              active
);
  logic [MS_W-1:0]   ms_cnt;
  logic [CODE_W-1:0] sel;
  logic              por;
  logic [MS_W-1:0]   target;

  assign target = hold_ms(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      ms_cnt <= '0;
      sel    <= POR_CODE;
      por    <= 1'b1;
    end else if (restart) begin
      active <= 1'b1;
      ms_cnt <= '0;
      sel    <= por ? POR_CODE : code_i;
    end else if (active && tick) begin
      if (ms_cnt == target - 1'b1) begin
        active <= 1'b0;
        por    <= 1'b0;
      end else begin
        ms_cnt <= ms_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer
  import srt_pkg::*;
#(
  parameter int CYC_PER_MS  = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok_i,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic              swrst_wr_i,
  input  logic              swrst_data_i,
  output logic              rst_pull_o,
  output logic              rst_status_o,
  output logic              trip_o,
  output logic              swrst_bit_o
);
  logic ok_s;
  logic sw_req;
  logic restart;
  logic tick;
  logic active;

  srt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(supply_ok_i), .q(ok_s)
  );

  assign sw_req  = swrst_wr_i && swrst_data_i;
  assign restart = !ok_s || sw_req;

  srt_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .clr(restart || !active), .en(active), .tick(tick)
  );

  srt_hold_ctrl u_hold (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .code_i(delay_code_i), .active(active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_o      <= 1'b1;
      swrst_bit_o <= 1'b0;
    end else begin
      trip_o <= !ok_s;
      if (sw_req)    swrst_bit_o <= 1'b1;
      else if (tick) swrst_bit_o <= 1'b0;
    end
  end

  assign rst_pull_o   = active;
  assign rst_status_o = active;
endmodule

// File: rtl/sup_rst_timer_chk.sv
module sup_rst_timer_chk #(
  parameter int CYC_PER_MS = 100000
) (
  input logic clk,
  input logic rst,
  input logic swrst_wr_i,
  input logic swrst_data_i,
  input logic rst_pull_o,
  input logic trip_o,
  input logic swrst_bit_o
);
  localparam int MIN_HOLD = 125 * CYC_PER_MS;
  int unsigned since;

  always_ff @(posedge clk) begin
    if (rst || trip_o || (swrst_wr_i && swrst_data_i)) since <= 0;
    else if (since < 32'hFFFF_FFF0)                    since <= since + 1;
  end

  p_trip_holds_r2: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> rst_pull_o);

  p_swrst_now_r5: assert property (@(posedge clk) disable iff (rst)
    (swrst_wr_i && swrst_data_i) |=> (rst_pull_o && swrst_bit_o));

  p_bit_clears_active_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(swrst_bit_o) |-> rst_pull_o);

  p_min_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_o) |-> (since >= MIN_HOLD - 1));

  p_release_clean_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_o) |-> !trip_o);
endmodule

bind sup_rst_timer sup_rst_timer_chk #(.CYC_PER_MS(CYC_PER_MS)) u_chk (
  .clk(clk), .rst(rst), .swrst_wr_i(swrst_wr_i), .swrst_data_i(swrst_data_i),
  .rst_pull_o(rst_pull_o), .trip_o(trip_o), .swrst_bit_o(swrst_bit_o)
);

// File: tb/test_sup_rst_timer.sv
`timescale 1ns/1ps
module test_sup_rst_timer;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok_i = 1'b1;
  logic [1:0] delay_code_i = 2'b00;
  logic       swrst_wr_i = 1'b0;
  logic       swrst_data_i = 1'b0;
  logic       rst_pull_o, rst_status_o, trip_o, swrst_bit_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sup_rst_timer #(.CYC_PER_MS(CYC)) i_sup_rst_timer (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i), .delay_code_i(delay_code_i),
    .swrst_wr_i(swrst_wr_i), .swrst_data_i(swrst_data_i),
    .rst_pull_o(rst_pull_o), .rst_status_o(rst_status_o),
    .trip_o(trip_o), .swrst_bit_o(swrst_bit_o)
  );

  function automatic int hold_cyc(input logic [1:0] code);
    return (125 << code) * CYC;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_release(output int j);
    j = 0;
    while (rst_pull_o && j < 20000) begin
      @(negedge clk);
      j++;
    end
  endtask

  task automatic sw_write(input logic val);
    swrst_wr_i = 1'b1;
    swrst_data_i = val;
    @(negedge clk);
    swrst_wr_i = 1'b0;
    swrst_data_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    int j;
    int flag;
    logic [1:0] code;
    void'($urandom(1234));

    repeat (5) @(negedge clk);
    // R10: state while in block reset
    check("R10 pull in reset", rst_pull_o, 1);
    check("R10 trip in reset", trip_o, 1);
    check("R10 status in reset", rst_status_o, 1);
    check("R10 bit in reset", swrst_bit_o, 0);

    // R10: first hold uses 1000 ms although code is 00
    rst = 1'b0;
    count_release(j);
    check("R10 power-on hold", j, hold_cyc(2'b11) + 2);
    check("R9 trip after recovery", trip_o, 0);
    check("R9 status after release", rst_status_o, 0);

    // R6: bit set, then cleared on first millisecond while still active
    delay_code_i = 2'b00;
    sw_write(1'b1);
    check("R5 pull after write", rst_pull_o, 1);
    check("R6 bit after write", swrst_bit_o, 1);
    repeat (CYC - 1) @(negedge clk);
    check("R6 bit before first ms", swrst_bit_o, 1);
    @(negedge clk);
    check("R6 bit cleared", swrst_bit_o, 0);
    check("R6 still active", rst_pull_o, 1);
    count_release(j);
    check("R5 release after write", j + CYC, hold_cyc(2'b00));

    // R1/R5: random codes via software reset
    for (int i = 0; i < 6; i++) begin
      code = 2'($urandom_range(0, 3));
      delay_code_i = code;
      repeat ($urandom_range(1, 5)) @(negedge clk);
      sw_write(1'b1);
      count_release(j);
      check("R1 hold for code", j, hold_cyc(code));
    end

    // R7: write of zero is ignored
    sw_write(1'b0);
    flag = 0;
    for (int i = 0; i < 20; i++) begin
      if (rst_pull_o || swrst_bit_o) flag = 1;
      @(negedge clk);
    end
    check("R7 zero write ignored", flag, 0);

    // R2: supply failure
    supply_ok_i = 1'b0;
    j = 0;
    while (!rst_pull_o && j < 20) begin
      @(negedge clk);
      j++;
    end
    check("R2 fail latency", j, 3);
    check("R2 trip flag", trip_o, 1);
    check("R9 status on fail", rst_status_o, 1);

    // R3: recovery with code 01
    repeat (10) @(negedge clk);
    delay_code_i = 2'b01;
    supply_ok_i = 1'b1;
    count_release(j);
    check("R3 recovery hold", j, hold_cyc(2'b01) + 2);

    // R4: dip during hold restarts the timer
    delay_code_i = 2'b00;
    supply_ok_i = 1'b0;
    repeat (10) @(negedge clk);
    supply_ok_i = 1'b1;
    repeat (200) @(negedge clk);
    supply_ok_i = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok_i = 1'b1;
    count_release(j);
    check("R4 restart after dip", j, hold_cyc(2'b00) + 2);

    // R8: second write extends the hold
    sw_write(1'b1);
    repeat (300) @(negedge clk);
    sw_write(1'b1);
    count_release(j);
    check("R8 extended hold", j, hold_cyc(2'b00));

    // R11: code change mid-hold is ignored
    delay_code_i = 2'b00;
    sw_write(1'b1);
    delay_code_i = 2'b11;
    count_release(j);
    check("R11 latched code", j, hold_cyc(2'b00));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule